// File: doc/BRIEF.md
# Peripheral Bus Cycle Sequencer

This block sits between a host processor and two slow targets: a local peripheral bus and a removable flash card bus. When the host starts a read or write with one of the two target selects low, the sequencer runs a fixed series of states. It first enables the host-side data buffer. One clock later it enables the device-side buffer and drives a device read or write strobe for a number of clocks taken from the selected target's wait count. It then releases the strobe while the buffers stay on. Last, it pulls the host ready line low for exactly one clock. The host holds address and select for the whole cycle, so the shortened device strobe always ends while they are still valid.

Read data is caught by a latch enable that is open only while the device read strobe is active. It closes as the strobe ends, so a host that samples at the very end of its cycle still sees stable data. Cycle length never depends on a handshake from the device. Card accesses use the card wait count as a fixed figure with no wait input. A separate path turns an active-low interrupt from a dual-port memory into an active-high, registered host interrupt.

Top module: `pbus_seq`

## Requirements
- R1: During and right after a synchronous reset, host_rdy_n, host_buf_en_n, dev_buf_en_n, dev_rd_n and dev_wr_n are 1, rd_latch_en is 0, and host_irq is 0.
- R2: A cycle starts only when host_rd_n or host_wr_n is low and per_sel_n or card_sel_n is low. In its first clock only host_buf_en_n is low and both device strobes are high. With no select low, no output changes.
- R3: The device strobe for the cycle's direction (dev_rd_n when host_rd_n started it, otherwise dev_wr_n) is low for exactly W+1 clocks. W is per_wait when per_sel_n is low, or card_wait when only card_sel_n is low. The peripheral select wins when both are low. The other strobe stays high.
- R4: After the strobe goes high, HOLD_CYC clocks (default 1) pass before ready. In those clocks both buffer enables stay low.
- R5: host_rdy_n goes low W+HOLD_CYC+2 clocks after host_buf_en_n first goes low, and stays low for exactly one clock.
- R6: dev_buf_en_n is low only during the strobe and hold clocks. It is high in the first clock of a cycle and in the ready clock.
- R7: rd_latch_en is 1 exactly in the clocks where dev_rd_n is low. It is 0 for the whole of a write.
- R8: The wait count is captured when the cycle starts. A change to per_wait or card_wait later in the cycle has no effect on its length.
- R9: After a cycle ends, a new one starts only after both host_rd_n and host_wr_n have been seen high at a clock edge. A strobe held low past ready does not start a second cycle.
- R10: host_irq equals the inverse of dpram_irq_n sampled at the previous clock edge.
- R11: dev_rd_n and dev_wr_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| per_sel_n | input | 1 | Peripheral bus select, active low |
| card_sel_n | input | 1 | Flash card select, active low |
| per_wait | input | WAIT_W | Peripheral wait clocks |
| card_wait | input | WAIT_W | Fixed card wait clocks |
| dpram_irq_n | input | 1 | Dual-port memory interrupt, active low |
| host_rdy_n | output | 1 | Host ready, active low, one clock |
| host_buf_en_n | output | 1 | Host-side buffer enable, active low |
| dev_buf_en_n | output | 1 | Device-side buffer enable, active low |
| dev_rd_n | output | 1 | Device read strobe, active low |
| dev_wr_n | output | 1 | Device write strobe, active low |
| rd_latch_en | output | 1 | Read data latch enable, active high |
| host_irq | output | 1 | Host interrupt, active high |

## Verification
A wrong state or a bad wait count shows at the ports within the same cycle. It appears as a device strobe whose width differs from W+1, or as ready arriving at the wrong distance from the host buffer enable. The scoreboard measures both against the value it pushed for that access. A lost rearm flag shows as a second host-buffer assertion with nothing expected in the queue. A mis-timed latch or device buffer shows on the very clock where it differs from the strobe. The strobe priority, the target priority and the capture of the wait count are each exercised by accesses whose expected length can only match one interpretation.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_READY
  } seq_state_t;

  typedef struct packed {
    logic host_buf_en_n;
    logic dev_buf_en_n;
    logic dev_rd_n;
    logic dev_wr_n;
    logic rd_latch_en;
    logic host_rdy_n;
  } pbus_ctl_t;

  localparam pbus_ctl_t CTL_QUIET = '{
    host_buf_en_n: 1'b1,
    dev_buf_en_n:  1'b1,
    dev_rd_n:      1'b1,
    dev_wr_n:      1'b1,
    rd_latch_en:   1'b0,
    host_rdy_n:    1'b1
  };

  // Moore decode of the control outputs from a state and the cycle direction
  function automatic pbus_ctl_t ctl_decode(input seq_state_t st, input logic is_rd);
    pbus_ctl_t c;
    c = CTL_QUIET;
    case (st)
      ST_SETUP: c.host_buf_en_n = 1'b0;
      ST_STROBE: begin
        c.host_buf_en_n = 1'b0;
        c.dev_buf_en_n  = 1'b0;
        if (is_rd) begin
          c.dev_rd_n    = 1'b0;
          c.rd_latch_en = 1'b1;
        end else begin
          c.dev_wr_n    = 1'b0;
        end
      end
      ST_HOLD: begin
        c.host_buf_en_n = 1'b0;
        c.dev_buf_en_n  = 1'b0;
      end
      ST_READY: begin
        c.host_buf_en_n = 1'b0;
        c.host_rdy_n    = 1'b0;
      end
      default: c = CTL_QUIET;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pbus_wait_ctr.sv
`timescale 1ns/1ps
module pbus_wait_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pbus_seq_fsm.sv
`timescale 1ns/1ps
module pbus_seq_fsm
  import pbus_pkg::*;
#(
  parameter int WAIT_W   = 4,
  parameter int HOLD_CYC = 1,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              per_sel_n,
  input  logic              card_sel_n,
  input  logic [WAIT_W-1:0] per_wait,
  input  logic [WAIT_W-1:0] card_wait,
  input  logic              cnt_zero,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              cnt_dec,
  output seq_state_t        state_d,
  output logic              rd_d
);

  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  seq_state_t        state_q;
  logic              rd_q;
  logic              armed_q;
  logic              start;
  logic [WAIT_W-1:0] sel_wait;

  assign start    = armed_q && (!host_rd_n || !host_wr_n) && (!per_sel_n || !card_sel_n);
  // peripheral select has priority; the card count is a fixed figure, no handshake
  assign sel_wait = !per_sel_n ? per_wait : card_wait;

  always_comb begin
    state_d  = state_q;
    rd_d     = rd_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_SETUP;
          rd_d     = !host_rd_n;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(sel_wait);
        end
      end
      ST_SETUP: state_d = ST_STROBE;
      ST_STROBE: begin
        cnt_dec = 1'b1;
        if (cnt_zero) begin
          state_d  = ST_HOLD;
          cnt_load = 1'b1;
          cnt_val  = HOLD_LAST;
        end
      end
      ST_HOLD: begin
        cnt_dec = 1'b1;
        if (cnt_zero) state_d = ST_READY;
      end
      ST_READY: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      if ((state_q == ST_IDLE) && start) begin
        armed_q <= 1'b0;
      end else if (host_rd_n && host_wr_n) begin
        armed_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pbus_seq_outreg.sv
`timescale 1ns/1ps
module pbus_seq_outreg
  import pbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t state_d,
  input  logic       rd_d,
  input  logic       dpram_irq_n,
  output pbus_ctl_t  ctl_q,
  output logic       irq_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_QUIET;
      irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_decode(state_d, rd_d);
      irq_q <= !dpram_irq_n;
    end
  end

endmodule

// File: rtl/pbus_seq.sv
`timescale 1ns/1ps
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int WAIT_W   = 4,
  parameter int HOLD_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              per_sel_n,
  input  logic              card_sel_n,
  input  logic [WAIT_W-1:0] per_wait,
  input  logic [WAIT_W-1:0] card_wait,
  input  logic              dpram_irq_n,
  output logic              host_rdy_n,
  output logic              host_buf_en_n,
  output logic              dev_buf_en_n,
  output logic              dev_rd_n,
  output logic              dev_wr_n,
  output logic              rd_latch_en,
  output logic              host_irq
);

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int CNT_W  = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

  seq_state_t       state_d;
  logic             rd_d;
  logic             cnt_load;
  logic             cnt_dec;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  pbus_ctl_t        ctl_q;

  pbus_seq_fsm #(
    .WAIT_W  (WAIT_W),
    .HOLD_CYC(HOLD_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .host_rd_n (host_rd_n),
    .host_wr_n (host_wr_n),
    .per_sel_n (per_sel_n),
    .card_sel_n(card_sel_n),
    .per_wait  (per_wait),
    .card_wait (card_wait),
    .cnt_zero  (cnt_zero),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .cnt_dec   (cnt_dec),
    .state_d   (state_d),
    .rd_d      (rd_d)
  );

  pbus_wait_ctr #(
    .CNT_W(CNT_W)
  ) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(cnt_val),
    .dec     (cnt_dec),
    .zero    (cnt_zero)
  );

  pbus_seq_outreg u_out (
    .clk        (clk),
    .rst        (rst),
    .state_d    (state_d),
    .rd_d       (rd_d),
    .dpram_irq_n(dpram_irq_n),
    .ctl_q      (ctl_q),
    .irq_q      (host_irq)
  );

  assign host_rdy_n    = ctl_q.host_rdy_n;
  assign host_buf_en_n = ctl_q.host_buf_en_n;
  assign dev_buf_en_n  = ctl_q.dev_buf_en_n;
  assign dev_rd_n      = ctl_q.dev_rd_n;
  assign dev_wr_n      = ctl_q.dev_wr_n;
  assign rd_latch_en   = ctl_q.rd_latch_en;

endmodule

// File: rtl/pbus_seq_chk.sv
`timescale 1ns/1ps
module pbus_seq_chk (
  input logic clk,
  input logic rst,
  input logic host_rd_n,
  input logic host_wr_n,
  input logic per_sel_n,
  input logic card_sel_n,
  input logic dpram_irq_n,
  input logic host_rdy_n,
  input logic host_buf_en_n,
  input logic dev_buf_en_n,
  input logic dev_rd_n,
  input logic dev_wr_n,
  input logic rd_latch_en,
  input logic host_irq
);

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!dev_rd_n && !dev_wr_n));

  a_r5_ready_single: assert property (@(posedge clk) disable iff (rst)
    !host_rdy_n |=> host_rdy_n);

  a_r7_latch_follows_rd: assert property (@(posedge clk) disable iff (rst)
    rd_latch_en == !dev_rd_n);

  a_r6_buffers_under_strobe: assert property (@(posedge clk) disable iff (rst)
    (!dev_rd_n || !dev_wr_n) |-> (!dev_buf_en_n && !host_buf_en_n));

  a_r4_hold_before_ready: assert property (@(posedge clk) disable iff (rst)
    $fell(host_rdy_n) |-> (dev_rd_n && dev_wr_n && $past(dev_rd_n) && $past(dev_wr_n)));

  a_r2_start_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(host_buf_en_n) |-> ($past(!per_sel_n || !card_sel_n) && $past(!host_rd_n || !host_wr_n)
                              && dev_buf_en_n && dev_rd_n && dev_wr_n));

  a_r10_irq_invert: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (host_irq == !$past(dpram_irq_n)));

endmodule

bind pbus_seq pbus_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_rd_n    (host_rd_n),
  .host_wr_n    (host_wr_n),
  .per_sel_n    (per_sel_n),
  .card_sel_n   (card_sel_n),
  .dpram_irq_n  (dpram_irq_n),
  .host_rdy_n   (host_rdy_n),
  .host_buf_en_n(host_buf_en_n),
  .dev_buf_en_n (dev_buf_en_n),
  .dev_rd_n     (dev_rd_n),
  .dev_wr_n     (dev_wr_n),
  .rd_latch_en  (rd_latch_en),
  .host_irq     (host_irq)
);

// File: tb/tb_pbus_seq.sv
`timescale 1ns/1ps
module tb_pbus_seq;

  localparam int WAIT_W = 4;
  localparam int HOLD   = 1;

  typedef struct {
    bit is_rd;
    int w;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_rd_n = 1'b1;
  logic              host_wr_n = 1'b1;
  logic              per_sel_n = 1'b1;
  logic              card_sel_n = 1'b1;
  logic [WAIT_W-1:0] per_wait = '0;
  logic [WAIT_W-1:0] card_wait = '0;
  logic              dpram_irq_n = 1'b1;
  logic              host_rdy_n, host_buf_en_n, dev_buf_en_n;
  logic              dev_rd_n, dev_wr_n, rd_latch_en, host_irq;

  int   checks = 0;
  int   errors = 0;
  int   wd     = 0;
  bit   done   = 0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  pbus_seq #(.WAIT_W(WAIT_W), .HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst(rst), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .per_sel_n(per_sel_n), .card_sel_n(card_sel_n), .per_wait(per_wait),
    .card_wait(card_wait), .dpram_irq_n(dpram_irq_n), .host_rdy_n(host_rdy_n),
    .host_buf_en_n(host_buf_en_n), .dev_buf_en_n(dev_buf_en_n), .dev_rd_n(dev_rd_n),
    .dev_wr_n(dev_wr_n), .rd_latch_en(rd_latch_en), .host_irq(host_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: measures each cycle at the ports and compares with the scoreboard
  bit active = 0, rdy_chk = 0, prev_hb = 1;
  int cyc = 0, rdl = 0, wrl = 0, last_strb = 0;
  always @(negedge clk) begin
    if (rst) begin
      active = 0; rdy_chk = 0; prev_hb = 1;
    end else begin
      if (rdy_chk) begin
        chk(host_rdy_n == 1'b1, "R5 ready one clock", host_rdy_n, 1);
        rdy_chk = 0;
      end
      if (active) begin
        cyc++;
        if (!dev_rd_n) begin rdl++; last_strb = cyc; end
        if (!dev_wr_n) begin wrl++; last_strb = cyc; end
        chk(rd_latch_en == !dev_rd_n, "R7 latch vs read strobe", rd_latch_en, !dev_rd_n);
        chk(!(!dev_rd_n && !dev_wr_n), "R11 strobes exclusive", {dev_rd_n, dev_wr_n}, 3);
        if (dev_rd_n && dev_wr_n && host_rdy_n && last_strb > 0)
          chk(dev_buf_en_n == 1'b0 && host_buf_en_n == 1'b0, "R4 buffers on in hold",
              {host_buf_en_n, dev_buf_en_n}, 0);
        if (!host_rdy_n) begin
          exp_t e;
          e = sb_q.pop_front();
          chk(cyc == e.w + HOLD + 2, "R5 ready latency", cyc, e.w + HOLD + 2);
          chk(rdl == (e.is_rd ? e.w + 1 : 0), "R3/R8 read strobe width", rdl, e.is_rd ? e.w + 1 : 0);
          chk(wrl == (e.is_rd ? 0 : e.w + 1), "R3/R8 write strobe width", wrl, e.is_rd ? 0 : e.w + 1);
          chk(cyc - last_strb == HOLD + 1, "R4 hold gap", cyc - last_strb, HOLD + 1);
          chk(dev_buf_en_n == 1'b1, "R6 device buffer off at ready", dev_buf_en_n, 1);
          active  = 0;
          rdy_chk = 1;
        end
      end else begin
        if (!host_rdy_n) chk(0, "R5 ready outside a cycle", 0, 1);
        if (prev_hb && !host_buf_en_n) begin
          if (sb_q.size() == 0) begin
            chk(0, "R9/R2 unexpected cycle start", 1, 0);
          end else begin
            chk(dev_buf_en_n == 1'b1, "R6 device buffer delayed", dev_buf_en_n, 1);
            chk(dev_rd_n && dev_wr_n, "R2 no strobe in first clock", {dev_rd_n, dev_wr_n}, 3);
            active = 1; cyc = 0; rdl = 0; wrl = 0; last_strb = 0;
          end
        end
      end
      prev_hb = host_buf_en_n;
    end
  end

  // Driver: starts one host access and pushes its expectation
  task automatic do_cycle(input bit rd, input bit psel, input bit csel, input int pw,
                          input int cw, input int exp_w, input int extra, input int chg);
    exp_t e;
    @(negedge clk);
    per_wait = WAIT_W'(pw); card_wait = WAIT_W'(cw);
    per_sel_n = !psel; card_sel_n = !csel;
    host_rd_n = !rd; host_wr_n = rd;
    e.is_rd = rd; e.w = exp_w;
    sb_q.push_back(e);
    if (chg >= 0) begin
      @(negedge clk);
      per_wait = WAIT_W'(chg); card_wait = WAIT_W'(chg);
    end
    do @(negedge clk); while (host_rdy_n);
    repeat (extra) @(negedge clk);
    host_rd_n = 1; host_wr_n = 1; per_sel_n = 1; card_sel_n = 1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      done = 1;
      chk(0, "watchdog", wd, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({host_rdy_n, host_buf_en_n, dev_buf_en_n, dev_rd_n, dev_wr_n} == 5'b11111,
        "R1 strobes idle in reset", {host_rdy_n, host_buf_en_n, dev_buf_en_n, dev_rd_n, dev_wr_n}, 31);
    chk(rd_latch_en == 0 && host_irq == 0, "R1 latch and irq low", {rd_latch_en, host_irq}, 0);
    rst = 0;
    @(negedge clk);
    chk({host_rdy_n, host_buf_en_n, dev_buf_en_n, dev_rd_n, dev_wr_n} == 5'b11111,
        "R1 idle after reset", {host_rdy_n, host_buf_en_n, dev_buf_en_n, dev_rd_n, dev_wr_n}, 31);
    @(negedge clk);

    do_cycle(1, 1, 0, 0, 9, 0, 0, -1);    // R3 peripheral read, zero wait
    do_cycle(0, 1, 0, 3, 9, 3, 0, -1);    // R3 peripheral write
    do_cycle(1, 0, 1, 9, 5, 5, 0, -1);    // R3 card read uses card count
    do_cycle(1, 1, 1, 2, 7, 2, 0, -1);    // R3 peripheral select wins
    do_cycle(0, 0, 1, 0, 15, 15, 0, -1);  // R3 card write, largest count
    do_cycle(1, 1, 0, 4, 0, 4, 0, 9);     // R8 count change mid-cycle ignored
    do_cycle(0, 0, 1, 0, 6, 6, 0, 1);     // R8 card count change ignored
    do_cycle(1, 1, 0, 1, 0, 1, 5, -1);    // R9 strobe held past ready
    do_cycle(0, 1, 0, 2, 0, 2, 0, -1);    // R9 rearmed after release

    // R2: strobe with no select starts nothing
    @(negedge clk);
    host_rd_n = 0;
    repeat (4) begin
      @(negedge clk);
      chk(host_buf_en_n == 1 && host_rdy_n == 1, "R2 no select no cycle", host_buf_en_n, 1);
    end
    host_rd_n = 1;
    @(negedge clk);

    // R10: interrupt inversion one clock later
    dpram_irq_n = 0;
    @(negedge clk);
    chk(host_irq == 1, "R10 irq asserted", host_irq, 1);
    dpram_irq_n = 1;
    @(negedge clk);
    chk(host_irq == 0, "R10 irq released", host_irq, 0);

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R5 all cycles completed", sb_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule